// File: doc/BRIEF.md
# Aging-Adaptive Latency Judge

This block sits in front of a variable-latency multiplier. It gives each operand pair one clock cycle or two. The choice depends on how many zero bits the bypass-controlling operand holds: more zeros mean fewer active adder cells and a shorter path through the array. When two cycles are chosen, the block holds the multiplier's input registers closed for one extra cycle. During that cycle the operands stay stable and no new pair is taken.

The output timing-error registers report a late result with a one-cycle error pulse. Each pulse also forces a hold cycle, so the faulty operation is redone over two cycles. The block counts these pulses inside a window of accepted operations. If the count reaches a set threshold within one window, the block moves from its relaxed judge to its strict judge. The strict judge asks for one more zero bit, so fewer patterns qualify for one cycle as the circuit ages. The strict judge stays selected until reset.

Operands enter through a valid/ready handshake. A pair is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` goes low during a hold cycle and during any cycle that carries an error pulse. A producer that sees `in_ready` low must keep the same pair and `in_valid` asserted. `ireg_en` is the load enable for the multiplier's input registers and is high exactly on a transfer.

Top module: `latency_judge`

## Requirements
- R1: After reset, `hold` is 0, `strict_mode` is 0 (relaxed judge) and the error and operation counters are cleared.
- R2: In relaxed mode, an accepted pair whose judged operand has at least ZERO_N zero bits (default 8 of 16) is a one-cycle operation: `hold` stays 0 in the following cycle.
- R3: An accepted pair whose judged operand has fewer zero bits than the active limit raises `hold` for exactly the one following cycle.
- R4: `in_ready` is 0 whenever `hold` or `err_pulse` is 1, and is 1 otherwise. `ireg_en` equals `in_valid && in_ready`. No pair is taken while `in_ready` is 0.
- R5: With default SEL_MCAND = 0, only the multiplier operand `mplier` is judged. The multiplicand value has no effect on the decision.
- R6: An `err_pulse` in any cycle raises `hold` in the next cycle, which is the re-execution cycle.
- R7: An `err_pulse` that arrives while `hold` is already 1 keeps `hold` at 1 for one more cycle.
- R8: Errors are counted per window of WINDOW accepted pairs (default 16). Accepting the last pair of a window clears the error count, so errors spread across windows do not add up.
- R9: When the error count within a window reaches ERR_THRESH (default 4), `strict_mode` becomes 1 in the cycle after the pulse that reached it.
- R10: In strict mode, a pair needs at least ZERO_N+1 zero bits in the judged operand for one-cycle operation. A pair with exactly ZERO_N zeros takes two cycles.
- R11: `strict_mode` never returns to 0 except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pair can be taken this cycle |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier operand |
| err_pulse | input | 1 | Timing-error report from the output registers |
| ireg_en | output | 1 | Load enable for the multiplier input registers |
| hold | output | 1 | Second cycle of a two-cycle or re-executed operation |
| strict_mode | output | 1 | 1 when the strict judge is active |

## Verification
Two cases need care because two events land in the same cycle.

The first case is an error report that arrives while `hold` is already high from a two-cycle decision. The stall must stretch by one more cycle, and the error must still be counted toward the mode switch.

The second case is the cycle in which the threshold error lands while a producer keeps `in_valid` high. That pair must be refused in the error cycle and in the re-execution cycle. When it is finally accepted, it must be judged by the strict rule.

The bench provokes both cases with back-to-back stimulus. A behavioural model predicts `in_ready`, `ireg_en`, `hold` and `strict_mode`, and the bench compares all four on every clock.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic {
    JUDGE_RELAXED = 1'b0,
    JUDGE_STRICT  = 1'b1
  } judge_e;
endpackage

// File: rtl/lat_zero_judge.sv
// Classifies the operand on the input port as one-cycle or two-cycle work.
module lat_zero_judge #(
  parameter int W         = 16,
  parameter int ZERO_N    = 8,
  parameter bit SEL_MCAND = 1'b0
) (
  input  logic [W-1:0]        mcand,
  input  logic [W-1:0]        mplier,
  input  lat_pkg::judge_e     mode,
  output logic                fast
);
  localparam int ZW = $clog2(W + 1);
  localparam logic [ZW:0] LIM_RELAX  = (ZW + 1)'(ZERO_N);
  localparam logic [ZW:0] LIM_STRICT = (ZW + 1)'(ZERO_N + 1);

  logic [W-1:0] judged;

  generate
    if (SEL_MCAND) begin : g_col
      logic unused_other;
      assign judged       = mcand;
      assign unused_other = ^mplier;
    end else begin : g_row
      logic unused_other;
      assign judged       = mplier;
      assign unused_other = ^mcand;
    end
  endgenerate

  logic [ZW:0] zeros;
  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      zeros = zeros + {{ZW{1'b0}}, ~judged[i]};
    end
  end

  logic [ZW:0] limit;
  always_comb begin
    limit = (mode == lat_pkg::JUDGE_STRICT) ? LIM_STRICT : LIM_RELAX;
    fast  = (zeros >= limit);
  end
endmodule

// File: rtl/lat_err_monitor.sv
// Counts error pulses per window of accepted operations; selects the judge.
module lat_err_monitor #(
  parameter int WINDOW     = 16,
  parameter int ERR_THRESH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_take,
  input  logic            err_pulse,
  output lat_pkg::judge_e mode
);
  localparam int OW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int EW = $clog2(ERR_THRESH + 1);
  localparam logic [OW-1:0] OP_LAST  = OW'(WINDOW - 1);
  localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_THRESH);
  localparam logic [EW-1:0] ERR_EDGE = EW'(ERR_THRESH - 1);

  logic [OW-1:0] op_cnt;
  logic [EW-1:0] err_cnt;
  logic          win_end;

  assign win_end = op_take && (op_cnt == OP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_cnt <= '0;
    end else if (op_take) begin
      op_cnt <= win_end ? '0 : op_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (win_end) begin
      err_cnt <= '0;
    end else if (err_pulse && (err_cnt != ERR_TOP)) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= lat_pkg::JUDGE_RELAXED;
    end else if (err_pulse && (err_cnt >= ERR_EDGE)) begin
      mode <= lat_pkg::JUDGE_STRICT;
    end
  end
endmodule

// File: rtl/lat_hold_ctl.sv
// Handshake gating and the one-cycle hold for slow or re-executed operations.
module lat_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic err_pulse,
  input  logic fast,
  output logic in_ready,
  output logic ireg_en,
  output logic hold
);
  logic take;

  assign in_ready = !hold && !err_pulse;
  assign take     = in_valid && in_ready;
  assign ireg_en  = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= 1'b0;
    end else begin
      hold <= (take && !fast) || err_pulse;
    end
  end
endmodule

// File: rtl/latency_judge.sv
module latency_judge #(
  parameter int W          = 16,
  parameter int ZERO_N     = 8,
  parameter int WINDOW     = 16,
  parameter int ERR_THRESH = 4,
  parameter bit SEL_MCAND  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic         err_pulse,
  output logic         ireg_en,
  output logic         hold,
  output logic         strict_mode
);
  lat_pkg::judge_e mode;
  logic            fast;

  lat_zero_judge #(
    .W(W), .ZERO_N(ZERO_N), .SEL_MCAND(SEL_MCAND)
  ) u_judge (
    .mcand  (mcand),
    .mplier (mplier),
    .mode   (mode),
    .fast   (fast)
  );

  lat_hold_ctl u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .err_pulse (err_pulse),
    .fast      (fast),
    .in_ready  (in_ready),
    .ireg_en   (ireg_en),
    .hold      (hold)
  );

  lat_err_monitor #(
    .WINDOW(WINDOW), .ERR_THRESH(ERR_THRESH)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_take   (ireg_en),
    .err_pulse (err_pulse),
    .mode      (mode)
  );

  assign strict_mode = (mode == lat_pkg::JUDGE_STRICT);
endmodule

// File: rtl/latency_judge_chk.sv
module latency_judge_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic err_pulse,
  input logic ireg_en,
  input logic hold,
  input logic strict_mode
);
  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || err_pulse) |-> !in_ready);

  // R4
  load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ireg_en |-> (in_valid && in_ready));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> hold);

  // R3
  hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !err_pulse) |=> !hold);

  // R11
  strict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strict_mode |=> strict_mode);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!hold && !strict_mode));
endmodule

bind latency_judge latency_judge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .err_pulse   (err_pulse),
  .ireg_en     (ireg_en),
  .hold        (hold),
  .strict_mode (strict_mode)
);

// File: tb/latency_judge_bench.sv
module latency_judge_bench;
  localparam int W   = 16;
  localparam int N   = 8;
  localparam int WIN = 16;
  localparam int TH  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         err_pulse = 1'b0;
  logic         in_ready, ireg_en, hold, strict_mode;

  always #2.5 clk = ~clk;

  latency_judge #(
    .W(W), .ZERO_N(N), .WINDOW(WIN), .ERR_THRESH(TH), .SEL_MCAND(1'b0)
  ) u_latency_judge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand(mcand), .mplier(mplier), .err_pulse(err_pulse),
    .ireg_en(ireg_en), .hold(hold), .strict_mode(strict_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural reference state
  bit m_hold, m_strict;
  int m_ops, m_errs;

  function automatic int zeros_of(input logic [W-1:0] v);
    int z = 0;
    for (int i = 0; i < W; i++) if (v[i] == 1'b0) z++;
    return z;
  endfunction

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hold = 0; m_strict = 0; m_ops = 0; m_errs = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; err_pulse = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic step(input logic v, input logic [W-1:0] mc, input logic [W-1:0] mp,
                      input logic e, input string tag);
    bit exp_rdy, acc;
    int need;
    @(negedge clk);
    in_valid = v; mcand = mc; mplier = mp; err_pulse = e;
    #1;
    exp_rdy = !m_hold && !e;
    acc     = v && exp_rdy;
    cmp(tag, "in_ready", in_ready, exp_rdy);
    cmp(tag, "ireg_en", ireg_en, acc);
    cmp(tag, "hold", hold, m_hold);
    cmp(tag, "strict_mode", strict_mode, m_strict);
    @(posedge clk);
    need   = m_strict ? N + 1 : N;
    m_hold = (acc && (zeros_of(mp) < need)) || e;
    if (e) begin
      m_errs++;
      if (m_errs >= TH) m_strict = 1;
    end
    if (acc) begin
      m_ops++;
      if (m_ops == WIN) begin m_ops = 0; m_errs = 0; end
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1: reset state
    idle("R1");
    idle("R1");

    // R2: exactly 8 zeros -> one cycle, back-to-back accepted
    step(1'b1, 16'h1234, 16'h00FF, 1'b0, "R2");
    step(1'b1, 16'hFFFF, 16'hF0F0, 1'b0, "R2");
    step(1'b1, 16'h0001, 16'h0000, 1'b0, "R2");
    idle("R2");

    // R3/R4: 7 zeros -> two cycles, producer keeps offering
    step(1'b1, 16'h0003, 16'h01FF, 1'b0, "R3");
    step(1'b1, 16'h0004, 16'h00FF, 1'b0, "R4");
    step(1'b1, 16'h0004, 16'h00FF, 1'b0, "R4");
    idle("R3");

    // R5: multiplicand extremes do not change decision
    step(1'b1, 16'h0000, 16'hFFFF, 1'b0, "R5");
    idle("R5");
    step(1'b1, 16'hFFFF, 16'h0000, 1'b0, "R5");
    idle("R5");

    // R6: error pulse forces re-execution hold and blocks intake
    step(1'b1, 16'h0, 16'h0000, 1'b1, "R6");
    step(1'b1, 16'h0, 16'h0000, 1'b0, "R6");
    step(1'b1, 16'h0, 16'h0000, 1'b0, "R6");
    idle("R6");

    // R7: error during a two-cycle hold stretches it
    do_reset();
    step(1'b1, 16'h0, 16'hFFFF, 1'b0, "R7");
    step(1'b1, 16'h0, 16'h00FF, 1'b1, "R7");
    step(1'b1, 16'h0, 16'h00FF, 1'b0, "R7");
    step(1'b0, 16'h0, 16'h0, 1'b0, "R7");

    // R8: errors split across windows do not accumulate
    do_reset();
    for (int k = 0; k < TH - 1; k++) begin
      step(1'b0, 16'h0, 16'h0, 1'b1, "R8");
      idle("R8");
    end
    for (int k = 0; k < WIN; k++) step(1'b1, 16'h0, 16'h0000, 1'b0, "R8");
    for (int k = 0; k < TH - 1; k++) begin
      step(1'b0, 16'h0, 16'h0, 1'b1, "R8");
      idle("R8");
    end
    idle("R8");

    // R9: one more error in this window reaches the threshold;
    // producer keeps offering an 8-zero pair through the switch
    step(1'b1, 16'h0, 16'h00FF, 1'b1, "R9");
    step(1'b1, 16'h0, 16'h00FF, 1'b0, "R9");
    // R10: accepted under strict rule -> two cycles
    step(1'b1, 16'h0, 16'h00FF, 1'b0, "R10");
    step(1'b1, 16'h0, 16'h007F, 1'b0, "R10");
    step(1'b1, 16'h0, 16'h007F, 1'b0, "R10");
    idle("R10");

    // R11: strict persists across windows, cleared only by reset
    for (int k = 0; k < WIN + 2; k++) step(1'b1, 16'h0, 16'h0000, 1'b0, "R11");
    idle("R11");
    do_reset();
    idle("R11");
    step(1'b1, 16'h0, 16'h00FF, 1'b0, "R11");
    idle("R11");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule